// File: doc/BRIEF.md
# Descending Stack Pointer Engine

This block owns the stack pointer of a byte-addressed machine whose stack grows toward lower addresses. A controller hands it one command at a time: push or pop of a 1, 2, 4 or 8 byte operand, a call that saves a link address and jumps, a return that restores a saved address and jumps, or a pointer initialisation. The engine checks the pointer step against the implemented address range. It then issues the memory beats the command needs, moves the pointer and reports completion, the popped value and any control-flow redirect.

Pushes store first and move the pointer down afterwards. Pops move the pointer up first and then load from the new position. An 8-byte operand travels as two 4-byte beats. Memory, instruction decode and register storage sit outside the block.

Top module: `stk_engine`

## Requirements
- R1: After reset the pointer `sp` reads 0, `busy` and `done` are low and no memory request is raised.
- R2: An initialisation command (op code 5) sets `sp` to `MEM_TOP - 7` and issues no memory beat.
- R3: A push (op code 1) with size code 0, 1, 2, 3 or 4 stores 1, 2, 4, 4 or 8 bytes at addresses starting at the current `sp`. The least significant byte goes to the lowest address. `sp` then drops by that byte count.
- R4: A pop (op code 2) first raises `sp` by the operand byte count and then loads that many bytes starting at the new `sp`, least significant byte at the lowest address. The value appears on `pop_data`, zero-extended, in the `done` cycle.
- R5: An 8-byte operand uses exactly two 4-byte beats, the low word at the lower address. Smaller operands use one beat whose `mem_bytes` equals the operand size.
- R6: A call (op code 3) pushes `cmd_link` as a 4-byte word and asserts `redirect_valid` with `redirect_addr` equal to `cmd_target` in the `done` cycle.
- R7: A return (op code 4) pops a 4-byte word and asserts `redirect_valid` with that word on `redirect_addr` in the `done` cycle.
- R8: A push or call faults when `sp` is less than the byte count, or when `sp` plus the byte count minus one exceeds `MEM_TOP`. A faulting command raises `fault` with `done`, issues no memory beat, leaves `sp` unchanged and does not redirect.
- R9: A pop or return faults, with the same effects as in R8, when the raised pointer plus the byte count minus one exceeds `MEM_TOP`.
- R10: `busy` is high from the cycle after acceptance through the `done` cycle. Commands presented while `busy` is high are ignored.
- R11: While `mem_req` is high and `mem_ack` is low, the request, address, direction and write data hold steady. Wait states change no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | 1 push, 2 pop, 3 call, 4 return, 5 init; others ignored |
| cmd_size | input | 3 | 0 byte, 1 halfword, 2 word, 3 float, 4 double |
| cmd_data | input | 64 | Push operand |
| cmd_link | input | ADDR_W | Return address saved by a call |
| cmd_target | input | ADDR_W | Jump target of a call |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion strobe |
| fault | output | 1 | Range fault, valid with done |
| pop_data | output | 64 | Popped value, valid with done |
| redirect_valid | output | 1 | Control transfer requested, with done |
| redirect_addr | output | ADDR_W | Transfer address |
| sp | output | ADDR_W | Current stack pointer |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | ADDR_W | Lowest byte address of the beat |
| mem_bytes | output | 4 | Bytes in the beat (1, 2 or 4) |
| mem_wdata | output | 32 | Write data, byte 0 at mem_addr |
| mem_ack | input | 1 | Beat accepted this cycle |
| mem_rdata | input | 32 | Read data, byte 0 from mem_addr |

## Verification
A corrupted pointer or latched operand size shows first on `mem_addr` or `mem_bytes` of the very next beat, so one transaction exposes it. A wrong fault decision is visible in the `done` cycle, either as a missing or spurious `fault` or as a beat that should not exist. A pointer update off by some bytes surfaces one cycle after `done` on `sp`. A stale word split only appears when the matching pop returns mismatched halves, which is why pushes and pops of every size are paired in the stimulus.

// File: rtl/stk_pkg.sv
package stk_pkg;

   localparam logic [2:0] OP_PUSH = 3'd1;
   localparam logic [2:0] OP_POP  = 3'd2;
   localparam logic [2:0] OP_CALL = 3'd3;
   localparam logic [2:0] OP_RET  = 3'd4;
   localparam logic [2:0] OP_INIT = 3'd5;

   localparam logic [3:0] LINK_BYTES = 4'd4;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_BEAT0,
      ST_BEAT1,
      ST_FIN
   } stk_state_e;

   // operand size code to byte count; unused codes fall back to a word
   function automatic logic [3:0] size_to_bytes(input logic [2:0] code);
      case (code)
         3'd0:    size_to_bytes = 4'd1;
         3'd1:    size_to_bytes = 4'd2;
         3'd4:    size_to_bytes = 4'd8;
         default: size_to_bytes = 4'd4;
      endcase
   endfunction

   function automatic logic op_known(input logic [2:0] op);
      op_known = (op >= OP_PUSH) && (op <= OP_INIT);
   endfunction

endpackage

// File: rtl/stk_bounds.sv
module stk_bounds #(
   parameter int          ADDR_W  = 32,
   parameter int unsigned MEM_TOP = 32'h0000_FFFF
) (
   input  logic [ADDR_W-1:0] cur_sp,
   input  logic [3:0]        nbytes,
   input  logic              is_push,
   output logic              step_fault,
   output logic [ADDR_W-1:0] step_sp,
   output logic [ADDR_W-1:0] step_base
);
   // two guard bits keep every sum below free of wrap
   localparam int             EW    = ADDR_W + 2;
   localparam logic [EW-1:0]  TOP_E = EW'(MEM_TOP);
   localparam logic [EW-1:0]  ONE_E = EW'(1);

   logic [EW-1:0] sp_e;
   logic [EW-1:0] nb_e;
   logic [EW-1:0] up_e;
   logic          dn_fault;
   logic          up_fault;

   assign sp_e = EW'(cur_sp);
   assign nb_e = EW'(nbytes);
   assign up_e = sp_e + nb_e;

   // store at sp, then step down
   assign dn_fault = (sp_e < nb_e) || ((up_e - ONE_E) > TOP_E);
   // step up, then load at the raised pointer
   assign up_fault = ((up_e + nb_e - ONE_E) > TOP_E);

   assign step_fault = is_push ? dn_fault : up_fault;
   assign step_sp    = is_push ? (cur_sp - ADDR_W'(nbytes)) : up_e[ADDR_W-1:0];
   assign step_base  = is_push ? cur_sp : up_e[ADDR_W-1:0];

endmodule

// File: rtl/stk_seq.sv
module stk_seq
   import stk_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [2:0]        op,
   input  logic [3:0]        nbytes,
   input  logic              fault_in,
   input  logic [ADDR_W-1:0] next_sp_in,
   input  logic [ADDR_W-1:0] base_in,
   input  logic [ADDR_W-1:0] init_sp,
   input  logic [63:0]       wdata_in,
   input  logic [ADDR_W-1:0] target_in,
   output logic              busy,
   output logic              done,
   output logic              fault,
   output logic [63:0]       pop_data,
   output logic              redirect_valid,
   output logic [ADDR_W-1:0] redirect_addr,
   output logic              sp_load,
   output logic [ADDR_W-1:0] sp_val,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [3:0]        mem_bytes,
   output logic [31:0]       mem_wdata,
   input  logic              mem_ack,
   input  logic [31:0]       mem_rdata
);
   localparam int          LANES     = 4;
   localparam logic [3:0]  BEAT_MAX  = 4'(LANES);
   localparam logic [3:0]  DBL_BYTES = 4'(2 * LANES);

   stk_state_e        state_q;
   logic [2:0]        op_q;
   logic [3:0]        nb_q;
   logic              fault_q;
   logic [ADDR_W-1:0] nsp_q;
   logic [ADDR_W-1:0] base_q;
   logic [63:0]       wd_q;
   logic [ADDR_W-1:0] tgt_q;
   logic [63:0]       rd_q;
   logic [31:0]       lane_rd;
   logic              dbl;
   logic              wr_op;

   assign dbl   = (nb_q == DBL_BYTES);
   assign wr_op = (op_q == OP_PUSH) || (op_q == OP_CALL);

   // bytes past the operand size read as zero
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign lane_rd[8*i +: 8] = (4'(i) < nb_q) ? mem_rdata[8*i +: 8] : 8'h00;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         op_q    <= '0;
         nb_q    <= '0;
         fault_q <= 1'b0;
         nsp_q   <= '0;
         base_q  <= '0;
         wd_q    <= '0;
         tgt_q   <= '0;
         rd_q    <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  op_q    <= op;
                  nb_q    <= nbytes;
                  fault_q <= fault_in && (op != OP_INIT);
                  nsp_q   <= next_sp_in;
                  base_q  <= base_in;
                  wd_q    <= wdata_in;
                  tgt_q   <= target_in;
                  rd_q    <= '0;
                  state_q <= ((op == OP_INIT) || fault_in) ? ST_FIN : ST_BEAT0;
               end
            end
            ST_BEAT0: begin
               if (mem_ack) begin
                  rd_q[31:0] <= lane_rd;
                  state_q    <= dbl ? ST_BEAT1 : ST_FIN;
               end
            end
            ST_BEAT1: begin
               if (mem_ack) begin
                  rd_q[63:32] <= mem_rdata;
                  state_q     <= ST_FIN;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy      = (state_q != ST_IDLE);
   assign done      = (state_q == ST_FIN);
   assign fault     = done && fault_q;
   assign pop_data  = rd_q;

   assign mem_req   = (state_q == ST_BEAT0) || (state_q == ST_BEAT1);
   assign mem_we    = mem_req && wr_op;
   assign mem_addr  = (state_q == ST_BEAT1) ? (base_q + ADDR_W'(LANES)) : base_q;
   assign mem_bytes = dbl ? BEAT_MAX : nb_q;
   assign mem_wdata = (state_q == ST_BEAT1) ? wd_q[63:32] : wd_q[31:0];

   assign sp_load   = done && !fault_q;
   assign sp_val    = (op_q == OP_INIT) ? init_sp : nsp_q;

   assign redirect_valid = done && !fault_q && ((op_q == OP_CALL) || (op_q == OP_RET));
   assign redirect_addr  = (op_q == OP_CALL) ? tgt_q : rd_q[ADDR_W-1:0];

endmodule

// File: rtl/stk_engine.sv
module stk_engine
   import stk_pkg::*;
#(
   parameter int          ADDR_W  = 32,
   parameter int unsigned MEM_TOP = 32'h0000_FFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [2:0]        cmd_size,
   input  logic [63:0]       cmd_data,
   input  logic [ADDR_W-1:0] cmd_link,
   input  logic [ADDR_W-1:0] cmd_target,
   output logic              busy,
   output logic              done,
   output logic              fault,
   output logic [63:0]       pop_data,
   output logic              redirect_valid,
   output logic [ADDR_W-1:0] redirect_addr,
   output logic [ADDR_W-1:0] sp,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [3:0]        mem_bytes,
   output logic [31:0]       mem_wdata,
   input  logic              mem_ack,
   input  logic [31:0]       mem_rdata
);
   localparam logic [ADDR_W-1:0] INIT_SP = ADDR_W'(MEM_TOP - 32'd7);

   if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_width
      $error("stk_engine: ADDR_W must lie in 8..32");
   end
   if (MEM_TOP < 32'd15) begin : g_bad_top
      $error("stk_engine: MEM_TOP too small for an 8-byte frame");
   end
   if (ADDR_W < 32) begin : g_top_range
      if (MEM_TOP >= (32'd1 << ADDR_W)) begin : g_bad_range
         $error("stk_engine: MEM_TOP exceeds the address width");
      end
   end

   logic              start;
   logic [3:0]        nbytes;
   logic              is_push;
   logic              step_fault;
   logic [ADDR_W-1:0] step_sp;
   logic [ADDR_W-1:0] step_base;
   logic [63:0]       wdata;
   logic              sp_load;
   logic [ADDR_W-1:0] sp_val;
   logic [ADDR_W-1:0] sp_q;

   assign start   = cmd_valid && !busy && op_known(cmd_op);
   assign is_push = (cmd_op == OP_PUSH) || (cmd_op == OP_CALL);
   assign nbytes  = ((cmd_op == OP_CALL) || (cmd_op == OP_RET)) ? LINK_BYTES
                                                               : size_to_bytes(cmd_size);
   assign wdata   = (cmd_op == OP_CALL) ? 64'(cmd_link) : cmd_data;

   stk_bounds #(
      .ADDR_W (ADDR_W),
      .MEM_TOP(MEM_TOP)
   ) u_bounds (
      .cur_sp    (sp_q),
      .nbytes    (nbytes),
      .is_push   (is_push),
      .step_fault(step_fault),
      .step_sp   (step_sp),
      .step_base (step_base)
   );

   stk_seq #(
      .ADDR_W(ADDR_W)
   ) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .start         (start),
      .op            (cmd_op),
      .nbytes        (nbytes),
      .fault_in      (step_fault),
      .next_sp_in    (step_sp),
      .base_in       (step_base),
      .init_sp       (INIT_SP),
      .wdata_in      (wdata),
      .target_in     (cmd_target),
      .busy          (busy),
      .done          (done),
      .fault         (fault),
      .pop_data      (pop_data),
      .redirect_valid(redirect_valid),
      .redirect_addr (redirect_addr),
      .sp_load       (sp_load),
      .sp_val        (sp_val),
      .mem_req       (mem_req),
      .mem_we        (mem_we),
      .mem_addr      (mem_addr),
      .mem_bytes     (mem_bytes),
      .mem_wdata     (mem_wdata),
      .mem_ack       (mem_ack),
      .mem_rdata     (mem_rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)       sp_q <= '0;
      else if (sp_load) sp_q <= sp_val;
   end

   assign sp = sp_q;

endmodule

// File: rtl/stk_engine_chk.sv
module stk_engine_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic              fault,
   input logic              redirect_valid,
   input logic [ADDR_W-1:0] sp,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [3:0]        mem_bytes,
   input logic [31:0]       mem_wdata,
   input logic              mem_ack
);
   a_r10_done_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);

   a_r10_idle_no_beat: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req);

   a_r11_beat_held: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                 && $stable(mem_wdata) && $stable(mem_bytes)));

   a_r8_fault_keeps_sp: assert property (@(posedge clk) disable iff (!rst_n)
      (done && fault) |=> $stable(sp));

   a_r3_sp_moves_only_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      !done |=> $stable(sp));

   a_r5_beat_size_legal: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_bytes == 4'd1 || mem_bytes == 4'd2 || mem_bytes == 4'd4));

   a_r6_redirect_clean: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_valid |-> (done && !fault));

endmodule

bind stk_engine stk_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .busy          (busy),
   .done          (done),
   .fault         (fault),
   .redirect_valid(redirect_valid),
   .sp            (sp),
   .mem_req       (mem_req),
   .mem_we        (mem_we),
   .mem_addr      (mem_addr),
   .mem_bytes     (mem_bytes),
   .mem_wdata     (mem_wdata),
   .mem_ack       (mem_ack)
);

// File: tb/stk_engine_tb_top.sv
module stk_engine_tb_top;
   localparam int          AW  = 32;
   localparam int unsigned TOP = 32'h0000_00FF;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [2:0]    cmd_op = '0;
   logic [2:0]    cmd_size = '0;
   logic [63:0]   cmd_data = '0;
   logic [AW-1:0] cmd_link = '0;
   logic [AW-1:0] cmd_target = '0;
   logic          busy, done, fault, redirect_valid;
   logic [63:0]   pop_data;
   logic [AW-1:0] redirect_addr, sp;
   logic          mem_req, mem_we, mem_ack;
   logic [AW-1:0] mem_addr;
   logic [3:0]    mem_bytes;
   logic [31:0]   mem_wdata, mem_rdata;

   int errors = 0;
   int checks = 0;
   int stall_n = 0;
   int wait_cnt = 0;
   int beats = 0;
   bit finished = 1'b0;

   logic [7:0] mem     [0:255];
   logic [7:0] ref_mem [0:255];
   logic [AW-1:0] model_sp = '0;

   typedef struct {
      logic          fault;
      logic          chk_rd;
      logic [63:0]   rd;
      logic          rv;
      logic [AW-1:0] ra;
      logic [AW-1:0] sp;
      string         tag;
   } exp_t;
   exp_t expq[$];

   always #5 clk = ~clk;

   stk_engine #(.ADDR_W(AW), .MEM_TOP(TOP)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_size(cmd_size), .cmd_data(cmd_data), .cmd_link(cmd_link),
      .cmd_target(cmd_target), .busy(busy), .done(done), .fault(fault),
      .pop_data(pop_data), .redirect_valid(redirect_valid),
      .redirect_addr(redirect_addr), .sp(sp), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_bytes(mem_bytes),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   // memory model: programmable wait states, little-endian bytes
   assign mem_ack = mem_req && (wait_cnt >= stall_n);

   always_comb begin
      for (int k = 0; k < 4; k++)
         mem_rdata[8*k +: 8] = mem[8'(mem_addr[7:0] + 8'(k))];
   end

   always @(posedge clk) begin
      wait_cnt <= (mem_req && !mem_ack) ? wait_cnt + 1 : 0;
      if (mem_req && mem_ack) beats <= beats + 1;
   end

   always @(negedge clk) begin
      if (mem_req && mem_ack && mem_we)
         for (int k = 0; k < 4; k++)
            if (k < int'(mem_bytes)) mem[8'(mem_addr[7:0] + 8'(k))] = mem_wdata[8*k +: 8];
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic int bytes_of(input logic [2:0] op, input logic [2:0] sz);
      if (op == 3'd3 || op == 3'd4) return 4;
      case (sz)
         3'd0: return 1;
         3'd1: return 2;
         3'd4: return 8;
         default: return 4;
      endcase
   endfunction

   // scoreboard monitor
   initial begin
      forever begin
         @(negedge clk);
         if (done) begin
            if (expq.size() == 0) begin
               chk(1'b0, "R10", "unexpected done", 64'd1, 64'd0);
            end else begin
               exp_t e;
               e = expq.pop_front();
               chk(fault == e.fault, e.tag, "fault", 64'(fault), 64'(e.fault));
               if (e.chk_rd) chk(pop_data == e.rd, e.tag, "pop_data", pop_data, e.rd);
               chk(redirect_valid == e.rv, e.tag, "redirect_valid",
                   64'(redirect_valid), 64'(e.rv));
               if (e.rv) chk(redirect_addr == e.ra, e.tag, "redirect_addr",
                             64'(redirect_addr), 64'(e.ra));
               @(negedge clk);
               chk(sp == e.sp, e.tag, "sp", 64'(sp), 64'(e.sp));
            end
         end
      end
   end

   // driver: model the expectation, queue it, drive one command
   task automatic run_cmd(input logic [2:0] op, input logic [2:0] sz,
                          input logic [63:0] data, input logic [AW-1:0] link,
                          input logic [AW-1:0] tgt, input string tag, input bit poke);
      exp_t e;
      int n, b0, exp_beats;
      logic [64:0] spx, upx, topx;
      logic [63:0] val;
      logic [63:0] wv;
      n = bytes_of(op, sz);
      spx = 65'(model_sp); upx = spx + 65'(n); topx = 65'(TOP);
      val = '0;
      e.fault = 1'b0; e.chk_rd = 1'b0; e.rd = '0; e.rv = 1'b0; e.ra = '0; e.tag = tag;
      exp_beats = 0;
      if (op == 3'd5) begin
         model_sp = AW'(TOP - 7);
      end else if (op == 3'd1 || op == 3'd3) begin
         wv = (op == 3'd3) ? 64'(link) : data;
         e.fault = (spx < 65'(n)) || (upx - 65'd1 > topx);
         if (!e.fault) begin
            for (int k = 0; k < n; k++) ref_mem[8'(model_sp[7:0] + 8'(k))] = wv[8*k +: 8];
            model_sp = model_sp - AW'(n);
            exp_beats = (n == 8) ? 2 : 1;
            if (op == 3'd3) begin e.rv = 1'b1; e.ra = tgt; end
         end
      end else begin
         e.fault = (upx + 65'(n) - 65'd1 > topx);
         if (!e.fault) begin
            model_sp = upx[AW-1:0];
            for (int k = 0; k < n; k++) val[8*k +: 8] = ref_mem[8'(model_sp[7:0] + 8'(k))];
            exp_beats = (n == 8) ? 2 : 1;
            e.chk_rd = 1'b1; e.rd = val;
            if (op == 3'd4) begin e.rv = 1'b1; e.ra = val[AW-1:0]; end
         end
      end
      e.sp = model_sp;
      expq.push_back(e);
      b0 = beats;
      cmd_valid = 1'b1; cmd_op = op; cmd_size = sz; cmd_data = data;
      cmd_link = link; cmd_target = tgt;
      @(negedge clk);
      if (poke) begin
         cmd_op = 3'd5;
         @(negedge clk);
      end
      cmd_valid = 1'b0;
      while (busy) @(negedge clk);
      @(negedge clk);
      chk(beats - b0 == exp_beats, tag, "memory beats", 64'(beats - b0), 64'(exp_beats));
   endtask

   initial begin
      for (int i = 0; i < 256; i++) begin
         mem[i] = 8'(i) ^ 8'h5A;
         ref_mem[i] = 8'(i) ^ 8'h5A;
      end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(sp == '0, "R1", "sp", 64'(sp), 64'd0);
      chk(!busy, "R1", "busy", 64'(busy), 64'd0);
      chk(!done, "R1", "done", 64'(done), 64'd0);
      chk(!mem_req, "R1", "mem_req", 64'(mem_req), 64'd0);

      run_cmd(3'd1, 3'd0, 64'h55, '0, '0, "R8 push below zero", 1'b0);
      run_cmd(3'd5, 3'd0, '0, '0, '0, "R2 init", 1'b0);
      chk(sp == AW'(TOP - 7), "R2", "init sp", 64'(sp), 64'(TOP - 7));
      run_cmd(3'd2, 3'd2, '0, '0, '0, "R4 pop word", 1'b0);
      run_cmd(3'd2, 3'd0, '0, '0, '0, "R4 pop byte", 1'b0);
      run_cmd(3'd2, 3'd1, '0, '0, '0, "R9 pop half past top", 1'b0);
      run_cmd(3'd5, 3'd0, '0, '0, '0, "R2 re-init", 1'b0);

      run_cmd(3'd1, 3'd2, 64'h11223344, '0, '0, "R3 push word", 1'b0);
      chk(mem[8'hF8] == 8'h44 && mem[8'hFB] == 8'h11, "R3", "little-endian bytes",
          64'({mem[8'hFB], mem[8'hF8]}), 64'h1144);
      run_cmd(3'd1, 3'd1, 64'hBEEF, '0, '0, "R3 push half", 1'b0);
      run_cmd(3'd1, 3'd0, 64'h7E, '0, '0, "R3 push byte", 1'b0);
      run_cmd(3'd1, 3'd3, 64'hCAFEF00D, '0, '0, "R3 push float", 1'b0);
      run_cmd(3'd1, 3'd4, 64'h0123456789ABCDEF, '0, '0, "R5 push double", 1'b0);
      chk(mem[8'hED] == 8'hEF && mem[8'hF1] == 8'h67, "R5", "low word at lower address",
          64'({mem[8'hF1], mem[8'hED]}), 64'h67EF);
      stall_n = 2;
      run_cmd(3'd2, 3'd4, '0, '0, '0, "R11 R5 pop double stalled", 1'b0);
      stall_n = 1;
      run_cmd(3'd2, 3'd3, '0, '0, '0, "R11 pop float stalled", 1'b0);
      stall_n = 0;
      run_cmd(3'd2, 3'd0, '0, '0, '0, "R4 pop byte back", 1'b0);
      run_cmd(3'd2, 3'd1, '0, '0, '0, "R4 pop half back", 1'b0);
      run_cmd(3'd2, 3'd2, '0, '0, '0, "R4 pop word back", 1'b0);

      run_cmd(3'd3, 3'd0, '0, 32'h1000_0040, 32'h2000_0100, "R6 call", 1'b0);
      chk(mem[8'hF8] == 8'h40, "R6", "link byte 0", 64'(mem[8'hF8]), 64'h40);
      run_cmd(3'd4, 3'd0, '0, '0, '0, "R7 return", 1'b0);

      stall_n = 3;
      run_cmd(3'd1, 3'd2, 64'hA5A5A5A5, '0, '0, "R10 ignore while busy", 1'b1);
      stall_n = 0;
      run_cmd(3'd2, 3'd2, '0, '0, '0, "R10 pop after ignore", 1'b0);

      run_cmd(3'd2, 3'd0, '0, '0, '0, "R4 pop byte high", 1'b0);
      run_cmd(3'd2, 3'd1, '0, '0, '0, "R4 pop half high", 1'b0);
      run_cmd(3'd1, 3'd4, 64'hDEAD, '0, '0, "R8 push past top", 1'b0);
      run_cmd(3'd4, 3'd0, '0, '0, '0, "R9 R7 return past top", 1'b0);

      chk(expq.size() == 0, "R10", "scoreboard drained", 64'(expq.size()), 64'd0);
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         chk(1'b0, "R10", "watchdog expired", 64'd1, 64'd0);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule